// File: doc/BRIEF.md
# Four-Pin GPIO Port Register Bank

This block is the register side of a small bidirectional general-purpose port with four pins. A bus front end selects one of four byte-wide registers by index, presents a write byte with a one-cycle write strobe, and reads back the selected register on a combinational read-data bus. A separate one-cycle read strobe tells the block when to sample the pins. The front end pulses it at the start of a read transfer, so the byte it shifts out stays constant until the next strobe.

Two registers control the pins. The direction register chooses, per pin, whether the output driver is enabled. The drive register holds the level to drive. A third register inverts selected bits of the sampled input byte on read. The input register shows the synchronised pin levels whatever the direction of each pin. The upper four bits of the three writable registers are ordinary storage. The upper four bits of the input register are fixed at one.

Both strobes are plain single-cycle pulses. The bank accepts a write or a sample in every cycle and never applies back-pressure, so the front end needs no ready signal and no transfer is ever stalled.

Top module: `gpio_quad_regbank`

## Requirements
- R1: After reset the drive register reads 0xFF, the inversion register 0x00 and the direction register 0xFF. The input register reads 0xFF while all pins are high. No pin driver is enabled.
- R2: Register index encoding: 0 selects the input register, 1 the drive register, 2 the inversion register and 3 the direction register. rd_data shows the selected register in the same cycle that reg_idx is presented.
- R3: A write strobe with index 1, 2 or 3 stores all eight bits of wr_data, including bits 7:4, and the stored value reads back from the following cycle.
- R4: A write strobe with index 0 is ignored. The drive, inversion and direction registers and the input read value stay unchanged.
- R5: Direction bit i = 1 disables pin i: pin_oe[i] = 0 and pin_out[i] = 0. Direction bit i = 0 gives pin_oe[i] = 1 and pin_out[i] = drive bit i. A write changes pin_oe and pin_out in the cycle after the clock edge that samples the write strobe.
- R6: Reading index 1 returns the stored drive byte, not the level present on the pins.
- R7: Input read bit i (i in 3:0) equals captured pin i XOR inversion bit i. Bits 7:4 always read 1, whatever inversion bits 7:4 hold.
- R8: The input register reflects pin levels for pins configured as outputs as well as for inputs.
- R9: Each pin passes through two synchroniser flops before capture. The capture register loads on a clock edge where rd_stb is high and otherwise holds. A pin change made just before edge e1 is captured by a strobe at edge e3 or later; strobes at e1 and e2 still capture the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 2 | Register index for reads and writes |
| wr_data | input | 8 | Write byte |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle pin-sample strobe |
| rd_data | output | 8 | Selected register contents |
| pin_in | input | 4 | Pin levels from the pads |
| pin_oe | output | 4 | Per-pin output-driver enable |
| pin_out | output | 4 | Per-pin drive level |

## Verification
The hardest case to reach from the ports is the synchroniser window. A pin change followed too soon by a sample strobe must capture the old level, and the strobe has to land on exactly the third edge to pick up the new one. The bench holds the strobe high across consecutive edges right after a pin change and reads the input register between edges. Random interleaving of writes to every index, including the read-only one, with samples under random pin patterns and inversion masks covers pins that are driven while their input level is read back.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;
  typedef enum logic [1:0] {
    IDX_PINS   = 2'd0,
    IDX_DRIVE  = 2'd1,
    IDX_INVERT = 2'd2,
    IDX_DIR    = 2'd3
  } gpio_idx_e;
endpackage

// File: rtl/gpio_quad_sampler.sv
module gpio_quad_sampler #(
  parameter int PIN_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] din,
  input  logic             sample,
  output logic [PIN_W-1:0] cap_q
);
  localparam int LAST = STAGES - 1;

  logic [PIN_W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '1;
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '1;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '1;
    else if (sample) cap_q <= chain[LAST];
  end
endmodule

// File: rtl/gpio_quad_regs.sv
module gpio_quad_regs
  import gpio_quad_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_idx_e        wr_idx,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] drive_q,
  output logic [REG_W-1:0] invert_q,
  output logic [REG_W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q  <= '1;
      invert_q <= '0;
      dir_q    <= '1;
    end else if (wr_en) begin
      unique case (wr_idx)
        IDX_DRIVE:  drive_q  <= wr_data;
        IDX_INVERT: invert_q <= wr_data;
        IDX_DIR:    dir_q    <= wr_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_quad_rdmux.sv
module gpio_quad_rdmux
  import gpio_quad_pkg::*;
#(
  parameter int PIN_W = 4,
  parameter int REG_W = 8
) (
  input  gpio_idx_e        idx,
  input  logic [PIN_W-1:0] cap,
  input  logic [REG_W-1:0] drive_q,
  input  logic [REG_W-1:0] invert_q,
  input  logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - PIN_W;

  logic [REG_W-1:0] pins_byte;
  assign pins_byte = {{PAD_W{1'b1}}, cap ^ invert_q[PIN_W-1:0]};

  always_comb begin
    unique case (idx)
      IDX_PINS:   rd_data = pins_byte;
      IDX_DRIVE:  rd_data = drive_q;
      IDX_INVERT: rd_data = invert_q;
      default:    rd_data = dir_q;
    endcase
  end
endmodule

// File: rtl/gpio_quad_regbank.sv
module gpio_quad_regbank
  import gpio_quad_pkg::*;
#(
  parameter int PIN_W       = 4,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_en,
  input  logic             rd_stb,
  output logic [REG_W-1:0] rd_data,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_oe,
  output logic [PIN_W-1:0] pin_out
);
  gpio_idx_e        idx;
  logic [PIN_W-1:0] cap_q;
  logic [REG_W-1:0] drive_q, invert_q, dir_q;

  assign idx = gpio_idx_e'(reg_idx);

  gpio_quad_sampler #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .sample(rd_stb), .cap_q(cap_q)
  );

  gpio_quad_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_data(wr_data),
    .drive_q(drive_q), .invert_q(invert_q), .dir_q(dir_q)
  );

  gpio_quad_rdmux #(.PIN_W(PIN_W), .REG_W(REG_W)) u_rdmux (
    .idx(idx), .cap(cap_q), .drive_q(drive_q), .invert_q(invert_q),
    .dir_q(dir_q), .rd_data(rd_data)
  );

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign pin_oe[i]  = ~dir_q[i];
    assign pin_out[i] = ~dir_q[i] & drive_q[i];
  end
endmodule

// File: rtl/gpio_quad_checker.sv
module gpio_quad_checker #(
  parameter int PIN_W = 4,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_idx,
  input logic [REG_W-1:0] wr_data,
  input logic             wr_en,
  input logic             rd_stb,
  input logic [REG_W-1:0] rd_data,
  input logic [PIN_W-1:0] pin_oe,
  input logic [PIN_W-1:0] pin_out,
  input logic [PIN_W-1:0] cap_q,
  input logic [REG_W-1:0] drive_q,
  input logic [REG_W-1:0] invert_q,
  input logic [REG_W-1:0] dir_q
);
  localparam int PAD_W = REG_W - PIN_W;

  p_wr_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 2'd1) |=> drive_q == $past(wr_data));

  p_wr_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 2'd0) |=>
      ($stable(drive_q) && $stable(invert_q) && $stable(dir_q)));

  p_dir_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 2'd3) |=> pin_oe == ~$past(wr_data[PIN_W-1:0]));

  p_no_drive_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  p_pad_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 2'd0) |-> rd_data[REG_W-1:PIN_W] == {PAD_W{1'b1}});

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb) |-> $stable(cap_q));
endmodule

bind gpio_quad_regbank gpio_quad_checker #(.PIN_W(PIN_W), .REG_W(REG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
  .wr_en(wr_en), .rd_stb(rd_stb), .rd_data(rd_data), .pin_oe(pin_oe),
  .pin_out(pin_out), .cap_q(cap_q), .drive_q(drive_q),
  .invert_q(invert_q), .dir_q(dir_q)
);

// File: tb/test_gpio_quad_regbank.sv
module test_gpio_quad_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_idx = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] pin_in = 4'hF;
  logic [3:0] pin_oe, pin_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  logic [7:0] m_drive = 8'hFF, m_inv = 8'h00, m_dir = 8'hFF;
  logic [3:0] m_cap = 4'hF;

  gpio_quad_regbank i_gpio_quad_regbank (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
    .wr_en(wr_en), .rd_stb(rd_stb), .rd_data(rd_data), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [1:0] idx);
    case (idx)
      2'd0:    return {4'hF, m_cap ^ m_inv[3:0]};
      2'd1:    return m_drive;
      2'd2:    return m_inv;
      default: return m_dir;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [7:0] val);
    reg_idx = idx;
    #1 val = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(k[1:0], v);
      check(req, v, exp_read(k[1:0]));
    end
    check({req, " R5 oe"}, {4'h0, pin_oe}, {4'h0, ~m_dir[3:0]});
    check({req, " R5 out"}, {4'h0, pin_out}, {4'h0, m_drive[3:0] & ~m_dir[3:0]});
  endtask

  task automatic do_write(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (idx)
      2'd1: m_drive = d;
      2'd2: m_inv = d;
      2'd3: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic do_sample(input logic [3:0] p);
    @(negedge clk); pin_in = p;
    @(negedge clk);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    m_cap = p;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset defaults, R2 index decode
    check_all("R1 R2 reset");

    // R3 full byte stored including upper bits
    do_write(2'd1, 8'h5A); check_all("R3 drive");
    do_write(2'd2, 8'hA0); check_all("R3 invert upper");
    // R7 upper inversion bits do not reach input read
    rd(2'd0, v); check("R7 pad ones", v, 8'hFF);
    do_write(2'd3, 8'h3C); check_all("R3 dir");

    // R4 write to index 0 ignored
    do_write(2'd0, 8'h00); check_all("R4 ignore");

    // R5 one cycle after the write edge
    @(negedge clk);
    reg_idx = 2'd3; wr_data = 8'hF0; wr_en = 1'b1;
    #1 check("R5 before edge", {4'h0, pin_oe}, {4'h0, ~m_dir[3:0]});
    @(negedge clk); wr_en = 1'b0; m_dir = 8'hF0;
    check("R5 after edge", {4'h0, pin_oe}, 8'h0F);
    check("R5 out value", {4'h0, pin_out}, {4'h0, m_drive[3:0]});

    // R6/R8: all pins driving, pins read back opposite level
    do_write(2'd1, 8'h0F);
    do_write(2'd2, 8'h00);
    do_sample(4'h0);
    rd(2'd1, v); check("R6 latch not pin", v, 8'h0F);
    rd(2'd0, v); check("R8 pin on output", v, 8'hF0);

    // R7 inversion
    do_write(2'd2, 8'h05);
    rd(2'd0, v); check("R7 invert", v, 8'hF5);

    // R9 synchroniser window
    do_sample(4'hA);
    @(negedge clk); pin_in = 4'h5; rd_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(2'd0, v); check("R9 early strobe old", v, {4'hF, 4'hA ^ m_inv[3:0]});
    @(negedge clk); rd_stb = 1'b0; m_cap = 4'h5;
    rd(2'd0, v); check("R9 third edge new", v, {4'hF, 4'h5 ^ m_inv[3:0]});
    // R9 hold without strobe
    @(negedge clk); pin_in = 4'hC;
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R9 hold", v, {4'hF, 4'h5 ^ m_inv[3:0]});

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 2);
      if (op == 0) do_sample(4'($urandom));
      else         do_write(2'($urandom), 8'($urandom));
      check_all("R2 R3 R4 R5 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule